// File: doc/BRIEF.md
# Quad DAC serial command receiver

This block is the digital front end of a four-channel, 8-bit serial DAC. It runs on a system clock. It takes four asynchronous control pins: a serial clock, serial data, a frame-latch strobe and an active-low update strobe. Data bits are captured on each falling edge of the serial clock. The falling edge of the latch strobe closes the frame. An 11-bit frame names a channel, a gain flag and an 8-bit code, and it writes that channel's input register.

Each channel is double-buffered. If the update strobe is low when a frame is latched, the selected channel's output register also takes the new value at once. If the update strobe is high, the value waits in the input register. The next falling edge of the update strobe then copies all four input registers to the outputs in the same cycle. A frame that is too short is dropped, and a one-cycle error pulse is raised. A frame that is too long keeps only its last 11 bits.

Top module: `quad_dac_rx`

## Requirements
- R1: After reset every channel holds code 0 with gain flag 0 in both its input and output register, and `frame_err` is low.
- R2: A frame is sent MSB first. Frame bits 10:9 select the channel (00 = channel 0, 01 = 1, 10 = 2, 11 = 3). Bit 8 is the gain flag (1 means x2). Bits 7:0 are the code. Channel n's code appears on `dac_code[8n+7:8n]` and its gain flag on `dac_gain2[n]`.
- R3: If `upd_n` is low when `ser_load` falls on a valid frame, the selected channel's outputs change on the third system clock edge after the `ser_load` fall is sampled. The other channels are unchanged.
- R4: If `upd_n` is high when `ser_load` falls, no output changes. On the next fall of `upd_n`, all four outputs take their input register values in one cycle.
- R5: If more than 11 bits arrive before `ser_load` falls, only the last 11 bits received form the command.
- R6: If fewer than 11 bits arrive before `ser_load` falls, no register changes, and `frame_err` is high for exactly one cycle.
- R7: When a `ser_clk` fall and a `ser_load` fall are seen in the same system cycle, the bit is shifted in before the frame is judged.
- R8: When a `ser_load` fall and an `upd_n` fall are seen in the same system cycle, the frame is written first. All four outputs then load from the updated input registers.
- R9: Each `ser_load` fall restarts the bit count. Bits of a rejected frame never count toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial command data, MSB first |
| ser_load | input | 1 | Frame latch; its falling edge ends a frame |
| upd_n | input | 1 | Output update control; low means immediate update, and a falling edge updates all channels |
| dac_code | output | 32 | Latched output codes, 8 bits per channel, channel 0 in the low byte |
| dac_gain2 | output | 4 | Latched gain flag per channel (1 = x2) |
| frame_err | output | 1 | One-cycle pulse when a frame is rejected as short |

## Verification
Frames are sent to each of the four channels with both gain values, and with `upd_n` both low and high. This separates the immediate path from the deferred path and shows that a deferred write touches only its own input register. Over-length frames with leading junk bits check that the oldest bits are the ones dropped. Two back-to-back short frames, whose bits would add up to eleven, show that the count restarts after every latch. Coincident edges (clock with latch, and latch with update) fix the ordering inside a single system cycle. Every cycle is also compared against a behavioural model.

// File: rtl/quad_dac_rx.sv
module quad_dac_rx #(
  parameter int CODE_W = 8,
  parameter int CHANS  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ser_clk,
  input  logic                      ser_data,
  input  logic                      ser_load,
  input  logic                      upd_n,
  output logic [CHANS*CODE_W-1:0]   dac_code,
  output logic [CHANS-1:0]          dac_gain2,
  output logic                      frame_err
);
  localparam int SEL_W = $clog2(CHANS);
  localparam int FRAME = SEL_W + 1 + CODE_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  // pin order in sync vectors: {upd_n, ser_load, ser_data, ser_clk}
  logic [3:0] meta, sync, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      sync <= '0;
      prev <= '0;
    end else begin
      meta <= {upd_n, ser_load, ser_data, ser_clk};
      sync <= meta;
      prev <= sync;
    end
  end

  logic sclk_fall, load_fall, upd_fall, upd_lvl, data_bit;
  assign sclk_fall = prev[0] & ~sync[0];
  assign load_fall = prev[2] & ~sync[2];
  assign upd_fall  = prev[3] & ~sync[3];
  assign upd_lvl   = sync[3];
  assign data_bit  = sync[1];

  logic [FRAME-1:0] shreg, sh_nx;
  logic [CNT_W-1:0] cnt, cnt_nx;

  assign sh_nx  = sclk_fall ? {shreg[FRAME-2:0], data_bit} : shreg;
  assign cnt_nx = (sclk_fall && cnt != CNT_W'(FRAME)) ? cnt + CNT_W'(1) : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (load_fall) begin
      shreg <= '0;
      cnt   <= '0;
    end else begin
      shreg <= sh_nx;
      cnt   <= cnt_nx;
    end
  end

  logic              frame_ok;
  logic [SEL_W-1:0]  cmd_sel;
  logic              cmd_gain;
  logic [CODE_W-1:0] cmd_code;

  assign frame_ok = load_fall && (cnt_nx == CNT_W'(FRAME));
  assign cmd_sel  = sh_nx[FRAME-1 -: SEL_W];
  assign cmd_gain = sh_nx[CODE_W];
  assign cmd_code = sh_nx[CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_err <= 1'b0;
    else        frame_err <= load_fall && !frame_ok;
  end

  logic [CHANS*CODE_W-1:0] in_code;
  logic [CHANS-1:0]        in_gain;

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    logic              wr;
    logic [CODE_W-1:0] code_nx;
    logic              gain_nx;

    assign wr      = frame_ok && (cmd_sel == SEL_W'(c));
    assign code_nx = wr ? cmd_code : in_code[c*CODE_W +: CODE_W];
    assign gain_nx = wr ? cmd_gain : in_gain[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_code[c*CODE_W +: CODE_W]  <= '0;
        in_gain[c]                   <= 1'b0;
        dac_code[c*CODE_W +: CODE_W] <= '0;
        dac_gain2[c]                 <= 1'b0;
      end else begin
        in_code[c*CODE_W +: CODE_W] <= code_nx;
        in_gain[c]                  <= gain_nx;
        if (upd_fall) begin
          dac_code[c*CODE_W +: CODE_W] <= code_nx;
          dac_gain2[c]                 <= gain_nx;
        end else if (wr && !upd_lvl) begin
          dac_code[c*CODE_W +: CODE_W] <= cmd_code;
          dac_gain2[c]                 <= cmd_gain;
        end
      end
    end
  end

  assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME));

  assert_err_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  assert_err_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !$past(upd_fall)) |-> ($stable(dac_code) && $stable(dac_gain2) &&
                                         $stable(in_code) && $stable(in_gain)));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_fall && !load_fall) |=> ($stable(dac_code) && $stable(dac_gain2)));

  assert_deferred_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fall && upd_lvl && !upd_fall) |=> ($stable(dac_code) && $stable(dac_gain2)));

  assert_bulk_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fall && !load_fall) |=> (dac_code == $past(in_code) && dac_gain2 == $past(in_gain)));

  assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_fall |=> (cnt == '0));

endmodule

// File: tb/quad_dac_rx_test.sv
module quad_dac_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_data = 1'b0;
  logic        ser_load = 1'b1;
  logic        upd_n = 1'b0;
  logic [31:0] dac_code;
  logic [3:0]  dac_gain2;
  logic        frame_err;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int err_seen = 0;

  always #5 clk = ~clk;

  quad_dac_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .upd_n(upd_n), .dac_code(dac_code),
    .dac_gain2(dac_gain2), .frame_err(frame_err)
  );

  // behavioural reference model
  typedef struct packed { logic sc; logic da; logic ld; logic up; } pins_t;
  pins_t hq[$];
  bit    bits_q[$];
  int    nbits;
  int    m_in_code[4], m_out_code[4];
  bit    m_in_gain[4], m_out_gain[4];
  bit    m_err;

  always @(posedge clk) begin
    pins_t cur, old;
    if (!rst_n) begin
      hq.delete();
      bits_q.delete();
      nbits = 0;
      m_err = 0;
      for (int i = 0; i < 4; i++) begin
        m_in_code[i] = 0; m_out_code[i] = 0; m_in_gain[i] = 0; m_out_gain[i] = 0;
      end
    end else begin
      hq.push_back({ser_clk, ser_data, ser_load, upd_n});
      if (hq.size() > 4) void'(hq.pop_front());
      cur = (hq.size() >= 3) ? hq[hq.size()-3] : '0;
      old = (hq.size() >= 4) ? hq[hq.size()-4] : '0;
      m_err = 0;
      if (old.sc && !cur.sc) begin
        bits_q.push_back(cur.da);
        if (bits_q.size() > 11) void'(bits_q.pop_front());
        nbits++;
      end
      if (old.ld && !cur.ld) begin
        if (nbits >= 11) begin
          int v, ch;
          v = 0;
          foreach (bits_q[i]) v = v * 2 + int'(bits_q[i]);
          ch = (v >> 9) & 3;
          m_in_code[ch] = v & 255;
          m_in_gain[ch] = bit'((v >> 8) & 1);
          if (!cur.up) begin
            m_out_code[ch] = m_in_code[ch];
            m_out_gain[ch] = m_in_gain[ch];
          end
        end else begin
          m_err = 1;
        end
        bits_q.delete();
        nbits = 0;
      end
      if (old.up && !cur.up)
        for (int i = 0; i < 4; i++) begin
          m_out_code[i] = m_in_code[i];
          m_out_gain[i] = m_in_gain[i];
        end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [31:0] ec;
      logic [3:0]  eg;
      for (int i = 0; i < 4; i++) begin
        ec[i*8 +: 8] = m_out_code[i][7:0];
        eg[i] = m_out_gain[i];
      end
      total++;
      if (dac_code !== ec || dac_gain2 !== eg || frame_err !== m_err) begin
        bad++;
        $display("FAIL R2 model compare cyc=%0d actual=%h/%h/%b expected=%h/%h/%b",
                 cyc, dac_code, dac_gain2, frame_err, ec, eg, m_err);
      end
      if (frame_err) err_seen++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_data = v[i];
      ser_clk  = 1'b1;
      wait_n(4);
      ser_clk  = 1'b0;
      wait_n(3);
    end
  endtask

  task automatic strobe_load;
    @(negedge clk);
    ser_load = 1'b0;
    wait_n(4);
    ser_load = 1'b1;
    wait_n(6);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    shift_bits(v, n);
    strobe_load();
  endtask

  function automatic logic [31:0] frm(input int ch, input int g, input int code);
    return 32'((ch << 9) | (g << 8) | code);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      bad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    // R1 reset state
    chk("R1 code", 64'(dac_code), 64'h0);
    chk("R1 gain", 64'(dac_gain2), 64'h0);
    chk("R1 err", 64'(frame_err), 64'h0);

    // R2, R3: immediate update with latency check
    shift_bits(frm(1, 1, 8'hA5), 11);
    @(negedge clk);
    ser_load = 1'b0;
    wait_n(2);
    chk("R3 not yet", 64'(dac_code), 64'h0);
    wait_n(1);
    chk("R3 updated", 64'(dac_code), 64'h0000_A500);
    chk("R2 gain bit", 64'(dac_gain2), 64'b0010);
    wait_n(2);
    ser_load = 1'b1;
    wait_n(6);

    // R4: deferred updates
    upd_n = 1'b1;
    wait_n(6);
    send(frm(0, 0, 8'h3C), 11);
    send(frm(3, 1, 8'hFF), 11);
    chk("R4 held code", 64'(dac_code), 64'h0000_A500);
    chk("R4 held gain", 64'(dac_gain2), 64'b0010);
    @(negedge clk);
    upd_n = 1'b0;
    wait_n(3);
    chk("R4 bulk code", 64'(dac_code), 64'hFF00_A53C);
    chk("R4 bulk gain", 64'(dac_gain2), 64'b1010);

    // R5: long frame keeps last 11 bits
    send({3'b111, 11'(frm(2, 0, 8'h7E))}, 14);
    chk("R5 long frame", 64'(dac_code), 64'hFF7E_A53C);

    // R6: short frame rejected
    e0 = err_seen;
    send(frm(0, 1, 8'h01), 10);
    chk("R6 err pulses", 64'(err_seen - e0), 64'd1);
    chk("R6 no change code", 64'(dac_code), 64'hFF7E_A53C);
    chk("R6 no change gain", 64'(dac_gain2), 64'b1010);

    // R9: counter restarts; 10 + 1 bits must not form a frame
    e0 = err_seen;
    send(32'h3FF, 10);
    send(32'h1, 1);
    chk("R9 two rejects", 64'(err_seen - e0), 64'd2);
    chk("R9 no change", 64'(dac_code), 64'hFF7E_A53C);
    send(frm(0, 1, 8'h11), 11);
    chk("R9 next frame ok", 64'(dac_code), 64'hFF7E_A511);

    // R7: coincident serial clock and latch falls
    begin
      logic [31:0] f;
      f = frm(3, 0, 8'h5A);
      shift_bits(f >> 1, 10);
      @(negedge clk);
      ser_data = f[0];
      ser_clk  = 1'b1;
      wait_n(4);
      ser_clk  = 1'b0;
      ser_load = 1'b0;
      wait_n(4);
      ser_load = 1'b1;
      wait_n(6);
    end
    chk("R7 coincident code", 64'(dac_code), 64'h5A7E_A511);
    chk("R7 coincident gain", 64'(dac_gain2), 64'b0011);

    // R8: coincident latch and update falls
    upd_n = 1'b1;
    wait_n(6);
    send(frm(0, 0, 8'h22), 11);
    shift_bits(frm(1, 0, 8'h99), 11);
    @(negedge clk);
    ser_load = 1'b0;
    upd_n    = 1'b0;
    wait_n(4);
    ser_load = 1'b1;
    wait_n(6);
    chk("R8 coincident code", 64'(dac_code), 64'h5A7E_9922);
    chk("R8 coincident gain", 64'(dac_gain2), 64'b0000);

    wait_n(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule